// File: doc/BRIEF.md
# Programmable Vertical Blanking Generator

This block produces a line-aligned vertical blanking level for an interlaced deflection path. It counts pixel clocks within each line and lines within each field from the horizontal and vertical sync inputs. It measures the length of every field, and it decides whether each field is odd or even from where the vertical sync edge falls inside its line.

The blanking level rises a programmable number of lines (the lead) before the first complete line of the next field. It falls at the end of a line whose number depends on two mode bits, a tail extension and a reference-line count. The mode bits select one of four base offsets. In the modes that carry reference lines, the reference-line count moves the end of blanking later. Configuration is captured when a field opens, so writes made during a field take effect in the next one. Blanking stays active from reset until a complete field has been measured.

Top module: `vblank_gen`

## Requirements
- R1: After reset `vbl` is 1 and `field_odd` is 0. `vbl` stays 1 through the first two fields, until the second field start has captured a complete field length.
- R2: The first `hsync` rising edge after a `vsync` rising edge opens a new field: that line is line 1, and `vbl` is 1 from the start of line 1.
- R3: With lead L = `cfg_lead` > 0, `vbl` rises at the start of line N+1-L, where N is the measured length of the previous field. With L = 0, blanking begins at line 1 of the next field.
- R4: With `cfg_jump`=1 and `cfg_ref_sel`=0, `vbl` falls at the start of line `cfg_tail`+30, which is the end of line `cfg_tail`+29. The default width is 29 lines.
- R5: With `cfg_jump`=1 and `cfg_ref_sel`=1, `vbl` falls after line `cfg_ref_lines`+`cfg_tail`+25.
- R6: With `cfg_jump`=0 and `cfg_ref_sel`=0, `vbl` falls after line `cfg_tail`+22. The width is 22 lines with all fields at 0, and 24 lines with lead 2.
- R7: With `cfg_jump`=0 and `cfg_ref_sel`=1, `vbl` falls after line `cfg_ref_lines`+`cfg_tail`+18. This gives 20 lines for ref_lines=1, tail=1 and lead 0.
- R8: The configuration inputs are sampled only when a field opens. A change made in mid-field has no effect on `vbl` until the next field.
- R9: A `vsync` rise in the first half of a line (pixel count below half the measured line length) marks the coming field odd (`field_odd`=1). A rise later in the line marks it even. `field_odd` updates at line 1, and both parities follow the same line rules.
- R10: `vbl` changes only on clock edges where a rising `hsync` edge is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | Horizontal sync, rising edge starts a line |
| vsync | input | 1 | Vertical sync, rising edge marks a field boundary |
| cfg_jump | input | 1 | Jump-mode select |
| cfg_ref_sel | input | 1 | Reference-line blanking select |
| cfg_lead | input | LEAD_W | Lines of blanking before the next field |
| cfg_tail | input | TAIL_W | End-of-blanking extension in lines |
| cfg_ref_lines | input | REF_W | Reference-line count |
| vbl | output | 1 | Vertical blanking level |
| field_odd | output | 1 | 1 while the current field is odd |

## Verification
A wrong line counter or field-length register moves the `vbl` edges by whole lines. The bench compares `vbl` against its model on every line of every field, so such a fault shows at the first blanking edge after the bad state. A shadow register loaded at the wrong time shows within one field, because the bench rewrites the configuration in mid-field. A faulty parity decision shows on `field_odd` at line 1 of the next field.

// File: rtl/vbg_pkg.sv
package vbg_pkg;
  localparam int unsigned CFG_FW = 8;

  typedef struct packed {
    logic              jump;
    logic              ref_sel;
    logic [CFG_FW-1:0] lead;
    logic [CFG_FW-1:0] tail;
    logic [CFG_FW-1:0] ref_lines;
  } blank_cfg_t;

  // last line (1-based) of the field that is still blanked
  function automatic logic [15:0] last_blank_line(blank_cfg_t c);
    logic [15:0] t, r;
    t = {8'd0, c.tail};
    r = {8'd0, c.ref_lines};
    case ({c.jump, c.ref_sel})
      2'b10:   last_blank_line = 16'd29 + t;
      2'b11:   last_blank_line = 16'd25 + r + t;
      2'b01:   last_blank_line = 16'd18 + r + t;
      default: last_blank_line = 16'd22 + t;
    endcase
  endfunction

  // line at whose start the lead part of blanking begins
  function automatic logic [15:0] lead_line(logic [15:0] field_len, logic [CFG_FW-1:0] lead);
    lead_line = field_len + 16'd1 - {8'd0, lead};
  endfunction
endpackage

// File: rtl/vbg_edge.sv
module vbg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= din;
  end
  assign rise = din & ~q;
endmodule

// File: rtl/vbg_line_track.sv
module vbg_line_track #(
  parameter int unsigned PIX_W  = 12,
  parameter int unsigned LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_rise,
  input  logic              vs_rise,
  output logic              field_start,
  output logic [LINE_W-1:0] line_no,
  output logic [LINE_W-1:0] prev_len,
  output logic              field_odd,
  output logic              meas_done
);
  localparam logic [PIX_W-1:0]  PIX_MAX  = {PIX_W{1'b1}};
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic [PIX_W-1:0] pix_cnt, line_len;
  logic             vs_pend, odd_pend;
  logic [1:0]       start_cnt;
  logic             first_half;

  assign field_start = hs_rise & vs_pend;
  assign first_half  = pix_cnt < (line_len >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_cnt  <= '0;
      line_len <= '0;
    end else if (hs_rise) begin
      pix_cnt  <= '0;
      line_len <= (pix_cnt == PIX_MAX) ? PIX_MAX : pix_cnt + 1'b1;
    end else if (pix_cnt != PIX_MAX) begin
      pix_cnt  <= pix_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_pend  <= 1'b0;
      odd_pend <= 1'b0;
    end else if (vs_rise) begin
      vs_pend  <= 1'b1;
      odd_pend <= first_half;
    end else if (hs_rise) begin
      vs_pend  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_no   <= '0;
      prev_len  <= '0;
      field_odd <= 1'b0;
      start_cnt <= '0;
    end else if (field_start) begin
      line_no   <= {{(LINE_W-1){1'b0}}, 1'b1};
      prev_len  <= line_no;
      field_odd <= odd_pend;
      if (start_cnt != 2'd2) start_cnt <= start_cnt + 2'd1;
    end else if (hs_rise && line_no != LINE_MAX) begin
      line_no <= line_no + 1'b1;
    end
  end

  assign meas_done = (start_cnt == 2'd2);
endmodule

// File: rtl/vbg_cfg_shadow.sv
module vbg_cfg_shadow (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  vbg_pkg::blank_cfg_t cfg_in,
  output vbg_pkg::blank_cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/vbg_blank_ctrl.sv
module vbg_blank_ctrl #(
  parameter int unsigned LINE_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hs_rise,
  input  logic                field_start,
  input  logic                meas_done,
  input  logic [LINE_W-1:0]   line_no,
  input  logic [LINE_W-1:0]   prev_len,
  input  vbg_pkg::blank_cfg_t cfg,
  output logic                lead_hit,
  output logic                tail_hit,
  output logic                vbl
);
  localparam int unsigned PADW = 16 - LINE_W;

  logic [15:0] next_line, prev16, end_line, lead_ln;

  assign next_line = {{PADW{1'b0}}, line_no} + 16'd1;
  assign prev16    = {{PADW{1'b0}}, prev_len};
  assign end_line  = vbg_pkg::last_blank_line(cfg);
  assign lead_ln   = vbg_pkg::lead_line(prev16, cfg.lead);

  assign lead_hit = hs_rise & ~field_start & (cfg.lead != '0) &
                    (prev16 > {8'd0, cfg.lead}) & (next_line == lead_ln);
  assign tail_hit = hs_rise & ~field_start & (next_line == end_line + 16'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     vbl <= 1'b1;
    else if (!meas_done)            vbl <= 1'b1;
    else if (field_start)           vbl <= 1'b1;
    else if (lead_hit)              vbl <= 1'b1;
    else if (tail_hit)              vbl <= 1'b0;
  end
endmodule

// File: rtl/vblank_gen.sv
module vblank_gen #(
  parameter int unsigned PIX_W  = 12,
  parameter int unsigned LINE_W = 11,
  parameter int unsigned LEAD_W = 3,
  parameter int unsigned TAIL_W = 3,
  parameter int unsigned REF_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              cfg_jump,
  input  logic              cfg_ref_sel,
  input  logic [LEAD_W-1:0] cfg_lead,
  input  logic [TAIL_W-1:0] cfg_tail,
  input  logic [REF_W-1:0]  cfg_ref_lines,
  output logic              vbl,
  output logic              field_odd
);
  localparam int unsigned FW = vbg_pkg::CFG_FW;

  logic                hs_edge, vs_edge, field_start, meas_done;
  logic                lead_hit, tail_hit;
  logic [LINE_W-1:0]   line_no, prev_len;
  vbg_pkg::blank_cfg_t cfg_live, cfg_sh;

  assign cfg_live.jump      = cfg_jump;
  assign cfg_live.ref_sel   = cfg_ref_sel;
  assign cfg_live.lead      = {{(FW-LEAD_W){1'b0}}, cfg_lead};
  assign cfg_live.tail      = {{(FW-TAIL_W){1'b0}}, cfg_tail};
  assign cfg_live.ref_lines = {{(FW-REF_W){1'b0}}, cfg_ref_lines};

  vbg_edge u_hs_edge (.clk(clk), .rst_n(rst_n), .din(hsync), .rise(hs_edge));
  vbg_edge u_vs_edge (.clk(clk), .rst_n(rst_n), .din(vsync), .rise(vs_edge));

  vbg_line_track #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_track (
    .clk(clk), .rst_n(rst_n), .hs_rise(hs_edge), .vs_rise(vs_edge),
    .field_start(field_start), .line_no(line_no), .prev_len(prev_len),
    .field_odd(field_odd), .meas_done(meas_done)
  );

  vbg_cfg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .load(field_start), .cfg_in(cfg_live), .cfg_q(cfg_sh)
  );

  vbg_blank_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hs_rise(hs_edge), .field_start(field_start),
    .meas_done(meas_done), .line_no(line_no), .prev_len(prev_len), .cfg(cfg_sh),
    .lead_hit(lead_hit), .tail_hit(tail_hit), .vbl(vbl)
  );
endmodule

// File: rtl/vblank_gen_chk.sv
module vblank_gen_chk (
  input logic                clk,
  input logic                rst_n,
  input logic                hs_edge,
  input logic                field_start,
  input logic                meas_done,
  input logic                vbl,
  input vbg_pkg::blank_cfg_t cfg_sh
);
  assert_line_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_edge |=> $stable(vbl));
  assert_field_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> vbl);
  assert_unmeasured_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done |-> vbl);
  assert_fall_measured_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vbl) |-> $past(meas_done));
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> $stable(cfg_sh));
endmodule

bind vblank_gen vblank_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_edge(hs_edge), .field_start(field_start),
  .meas_done(meas_done), .vbl(vbl), .cfg_sh(cfg_sh)
);

// File: tb/test_vblank_gen.sv
`timescale 1ns/1ps
module test_vblank_gen;
  localparam int LINE_CLKS = 16;
  localparam int NF        = 16;

  logic clk = 1'b0, rst_n = 1'b0, hsync = 1'b0, vsync = 1'b0;
  logic cfg_jump = 1'b0, cfg_ref_sel = 1'b0;
  logic [2:0] cfg_lead = '0, cfg_tail = '0, cfg_ref_lines = '0;
  logic vbl, field_odd;

  int checks = 0, errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vblank_gen i_vblank_gen (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .cfg_jump(cfg_jump), .cfg_ref_sel(cfg_ref_sel), .cfg_lead(cfg_lead),
    .cfg_tail(cfg_tail), .cfg_ref_lines(cfg_ref_lines),
    .vbl(vbl), .field_odd(field_odd)
  );

  // configuration of one field: {jump, ref_sel, lead, tail, ref_lines}
  typedef struct { bit j; bit s; int lead; int tail; int refl; } fcfg_t;

  function automatic int blank_end(fcfg_t c);
    int base;
    base = c.j ? 25 : 18;
    return base + (c.s ? c.refl : 4) + c.tail;
  endfunction

  function automatic bit exp_blank(int ln, int prev_n, fcfg_t c);
    if (ln <= blank_end(c)) return 1'b1;
    if (c.lead != 0 && prev_n > c.lead && ln >= prev_n + 1 - c.lead) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string req_of(fcfg_t c);
    if (c.j) return c.s ? "R5" : "R4";
    return c.s ? "R7" : "R6";
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_cfg(fcfg_t c);
    cfg_jump = c.j; cfg_ref_sel = c.s;
    cfg_lead = c.lead[2:0]; cfg_tail = c.tail[2:0]; cfg_ref_lines = c.refl[2:0];
  endtask

  function automatic fcfg_t pick(int f);
    fcfg_t c;
    c = '{j:1'b0, s:1'b0, lead:0, tail:0, refl:0};
    case (f)
      3: ;                                                  // R6 default 22
      4: c.lead = 2;                                        // R6 width 24, R3
      5: begin c.s = 1; c.refl = 1; c.tail = 1; end         // R7 width 20
      6: c.j = 1;                                           // R4 default 29
      7: begin c.j = 1; c.s = 1; c.refl = 7; c.tail = 7; c.lead = 7; end // R5
      8: begin c.j = 1; c.tail = 7; c.lead = 1; end         // R4 upper tail
      default: begin
        c.j = 1'($urandom_range(0, 1)); c.s = 1'($urandom_range(0, 1));
        c.lead = $urandom_range(0, 7); c.tail = $urandom_range(0, 7);
        c.refl = $urandom_range(0, 7);
      end
    endcase
    return c;
  endfunction

  // one line; vs_ph >= 0 puts a vsync pulse at that pixel slot
  task automatic run_line(int ln, int f, int prev_n, fcfg_t cur, int vs_ph,
                          bit chk_odd, bit exp_odd, bit do_write, fcfg_t nxt);
    for (int j = 0; j < LINE_CLKS; j++) begin
      @(negedge clk);
      if (j == 1 && f >= 1) begin
        if (f < 2) check("R1", vbl, 1, $sformatf("vbl before measurement f%0d l%0d", f, ln));
        else if (ln == 1) check("R2", vbl, 1, $sformatf("vbl at line 1 f%0d", f));
        else check(req_of(cur), vbl, exp_blank(ln, prev_n, cur),
                   $sformatf("vbl f%0d l%0d lead%0d R3/R8", f, ln, cur.lead));
        if (chk_odd) check("R9", field_odd, exp_odd, $sformatf("parity f%0d", f));
      end
      hsync = (j < 2);
      vsync = (vs_ph >= 0 && j == vs_ph);
      if (do_write && j == 4) drive_cfg(nxt);
    end
  endtask

  initial begin
    fcfg_t cur, nxt;
    int prev_n, n_lines, ph;
    bit odd_next;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", vbl, 1, "vbl in reset");
    check("R1", field_odd, 0, "field_odd in reset");
    rst_n = 1'b1;
    cur = pick(1);
    drive_cfg(cur);
    // preamble: a few lines, vsync in the last one
    for (int p = 0; p < 4; p++) run_line(p + 1, 0, 0, cur, (p == 3) ? 3 : -1, 0, 0, 0, cur);
    prev_n = 0;
    odd_next = 1'b0;
    for (int f = 1; f <= NF; f++) begin
      n_lines = (f == 9) ? 70 : 80;
      nxt = pick(f + 1);
      ph = ($urandom_range(0, 1) == 1) ? 2 : 12;
      for (int ln = 1; ln <= n_lines; ln++)
        run_line(ln, f, prev_n, cur, (ln == n_lines) ? ph : -1,
                 (ln == 1 && f >= 3), odd_next, (ln == 5), nxt);
      odd_next = (ph == 2);
      prev_n = n_lines;
      cur = nxt;
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errs);
      $finish;
    end
  end
endmodule